// File: doc/BRIEF.md
# Waveform Buffer Burst Readout Sequencer

This block turns a burst read command for the waveform capture buffer into a stream of buffer word addresses, one for each 32-bit slot the serial port shifts out. It is the address side of the readout path. The serial shifter and the buffer memory sit outside it. The shifter asserts a strobe once per finished slot, and the sequencer moves to the next slot. The slot order depends on the channel subset that was requested and on whether the buffer holds fixed-rate samples or resampled samples.

Fixed-rate sample sets span 8 words, with one channel per word. Resampled sets span 4 words, and each word packs a voltage in its upper half and the matching current in its lower half. For that reason the block also outputs a select code. The code tells the shifter to send the whole word, to send either half sign-extended to 32 bits, or to send the CRC word in place of data. A dedicated channel code picks single-address mode. In that mode the requested word is read unaligned and either repeated or followed by the CRC.

Buffer addresses are word indices local to the buffer. They wrap modulo the buffer size. A stop input models the end of the transfer, which happens when chip select is released.

Top module: `wfb_burst_seq`

## Requirements
- R1: After reset, seq_active is 0, rd_addr is 0 and rd_sel is 00. While the sequencer is idle, rd_sel stays at 00 and rd_addr holds the current set base.
- R2: When cmd_load is 1 with a channel code other than 1111, cmd_addr is rounded down to the start of its sample set. For fixed-rate data this is a multiple of 8; for resampled data it is a multiple of 4. The first slot is shown on the cycle after the load.
- R3: With fixed-rate data (cmd_resamp=0) and code 0000, successive slots read set offsets 0 through 6 in ascending order, all with rd_sel=00 (whole word).
- R4: With fixed-rate data, codes 0001, 0010 and 0011 read the offset pairs {0,1}, {2,3} and {4,5} in that order. Code 0100 reads offset 6 alone. Codes 0101 to 1110 behave like 0000. After the last slot of a set, the next set starts 8 words higher.
- R5: With resampled data (cmd_resamp=1), each selected word is sent twice at the same address: first with rd_sel=01 (upper half, voltage), then with rd_sel=10 (lower half, current). Phase code p (0001 to 0011) uses offset p-1. Code 0000 uses offsets 0, 1 and 2 in turn.
- R6: With resampled data, the next set starts 4 words higher. Code 0100 reads offset 3 as a whole word (rd_sel=00), one slot per set.
- R7: Code 1111 is single-address mode. rd_addr equals cmd_addr with no rounding and rd_sel=00. If cmd_burst=0, every slot after the first reports rd_sel=11 (CRC).
- R8: In single-address mode with cmd_burst=1, every slot repeats the same address with rd_sel=00.
- R9: Set addresses wrap modulo 2^ADDR_W words.
- R10: seq_stop returns the block to idle (seq_active=0, rd_addr = set base, rd_sel=00). While idle, slot_next has no effect.
- R11: If cmd_load and slot_next are both 1 in the same cycle, the load takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Start a new burst with the command fields below |
| cmd_addr | input | ADDR_W | Requested buffer word index |
| cmd_chan | input | 4 | Channel subset code (1111 = single address) |
| cmd_resamp | input | 1 | 1 = resampled packed data, 0 = fixed-rate data |
| cmd_burst | input | 1 | Burst enable for single-address mode |
| slot_next | input | 1 | One 32-bit slot has been shifted; advance |
| seq_stop | input | 1 | Transfer ended (chip select released) |
| rd_addr | output | ADDR_W | Buffer word address for the current slot |
| rd_sel | output | 2 | 00 word, 01 upper half, 10 lower half, 11 CRC |
| seq_active | output | 1 | A burst is in progress |

## Verification
The bench builds the block with its default parameters: ADDR_W=11, FIX_LG=3 and RES_LG=2. That gives a 2048-word buffer with set strides of 8 and 4 words. The small buffer lets directed bursts that start a few words below the top reach the wrap back to word 0, in both data types, within a handful of slots. Starting addresses are picked in the middle of sample sets so that rounding down is visible on every channel code tested. Both exits of single-address mode are covered: the repeated word and the CRC slot.

// File: rtl/wfb_seq_pkg.sv
package wfb_seq_pkg;

  // Slot output select encodings
  localparam logic [1:0] SEL_FULL = 2'b00;
  localparam logic [1:0] SEL_HI   = 2'b01;
  localparam logic [1:0] SEL_LO   = 2'b10;
  localparam logic [1:0] SEL_CRC  = 2'b11;

  // Channel subset codes
  localparam logic [3:0] CODE_ALL    = 4'h0;
  localparam logic [3:0] CODE_NEU    = 4'h4;
  localparam logic [3:0] CODE_SINGLE = 4'hF;

  // Slot counter width and largest slot index (fixed-rate, all channels)
  localparam int unsigned SLOT_W    = 3;
  localparam int unsigned SLOT_MAX  = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_SINGLE = 2'd2,
    ST_CRC    = 2'd3
  } seq_st_e;

endpackage

// File: rtl/wfb_slot_map.sv
// Decodes (data type, channel code, slot index) into set offset, half select
// and an end-of-set flag.
module wfb_slot_map
  import wfb_seq_pkg::*;
#(
  parameter int unsigned OFF_W = 3
) (
  input  logic              resamp,
  input  logic [3:0]        chan,
  input  logic [SLOT_W-1:0] slot,
  output logic [OFF_W-1:0]  off,
  output logic [1:0]        sel,
  output logic              last
);

  logic [1:0] ph;
  logic       is_phase;

  assign ph       = chan[1:0] - 2'd1;
  assign is_phase = (chan == 4'h1) || (chan == 4'h2) || (chan == 4'h3);

  always_comb begin
    off  = '0;
    sel  = SEL_FULL;
    last = 1'b0;
    if (!resamp) begin
      if (is_phase) begin
        off  = OFF_W'({ph, slot[0]});
        last = slot[0];
      end else if (chan == CODE_NEU) begin
        off  = OFF_W'(6);
        last = 1'b1;
      end else begin
        off  = OFF_W'(slot);
        last = (slot == SLOT_W'(SLOT_MAX));
      end
    end else begin
      if (is_phase) begin
        off  = OFF_W'(ph);
        sel  = slot[0] ? SEL_LO : SEL_HI;
        last = slot[0];
      end else if (chan == CODE_NEU) begin
        off  = OFF_W'(3);
        last = 1'b1;
      end else begin
        off  = OFF_W'(slot[SLOT_W-1:1]);
        sel  = slot[0] ? SEL_LO : SEL_HI;
        last = (slot == SLOT_W'(5));
      end
    end
  end

endmodule

// File: rtl/wfb_set_base.sv
// Holds the current sample-set base, aligns it on load, steps it by the
// data-type stride, wrapping modulo the buffer size.
module wfb_set_base #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned FIX_LG = 3,
  parameter int unsigned RES_LG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_raw,
  input  logic              resamp,
  input  logic              adv,
  output logic [ADDR_W-1:0] base
);

  localparam logic [ADDR_W-1:0] FIX_STRIDE = ADDR_W'(1) << FIX_LG;
  localparam logic [ADDR_W-1:0] RES_STRIDE = ADDR_W'(1) << RES_LG;
  localparam logic [ADDR_W-1:0] FIX_MASK   = ~(FIX_STRIDE - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] RES_MASK   = ~(RES_STRIDE - ADDR_W'(1));

  logic [ADDR_W-1:0] base_q, base_d, stride;
  logic              base_en;

  assign stride  = resamp ? RES_STRIDE : FIX_STRIDE;
  assign base_en = load | adv;

  always_comb begin
    base_d = base_q;
    if (load) begin
      if (load_raw)    base_d = load_addr;
      else if (resamp) base_d = load_addr & RES_MASK;
      else             base_d = load_addr & FIX_MASK;
    end else if (adv) begin
      base_d = base_q + stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign base = base_q;

  // R4 R6 R9: a set step moves the base by exactly one stride, modulo size
  a_r9_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (base_q == $past(base_q) + $past(stride)));

endmodule

// File: rtl/wfb_burst_seq.sv
module wfb_burst_seq
  import wfb_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned FIX_LG = 3,
  parameter int unsigned RES_LG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_chan,
  input  logic              cmd_resamp,
  input  logic              cmd_burst,
  input  logic              slot_next,
  input  logic              seq_stop,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_sel,
  output logic              seq_active
);

  localparam int unsigned OFF_W = FIX_LG;

  seq_st_e           st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [3:0]        chan_q, chan_d;
  logic              rs_q, rs_d;
  logic              burst_q, burst_d;
  logic              ctl_en;
  logic              adv;

  logic [OFF_W-1:0]  map_off;
  logic [1:0]        map_sel;
  logic              map_last;
  logic [ADDR_W-1:0] base;

  wfb_slot_map #(.OFF_W(OFF_W)) u_map (
    .resamp (rs_q),
    .chan   (chan_q),
    .slot   (slot_q),
    .off    (map_off),
    .sel    (map_sel),
    .last   (map_last)
  );

  wfb_set_base #(.ADDR_W(ADDR_W), .FIX_LG(FIX_LG), .RES_LG(RES_LG)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_load),
    .load_addr (cmd_addr),
    .load_raw  (cmd_chan == CODE_SINGLE),
    .resamp    (cmd_load ? cmd_resamp : rs_q),
    .adv       (adv),
    .base      (base)
  );

  // Next-state
  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    chan_d  = chan_q;
    rs_d    = rs_q;
    burst_d = burst_q;
    adv     = 1'b0;
    if (cmd_load) begin
      st_d    = (cmd_chan == CODE_SINGLE) ? ST_SINGLE : ST_STREAM;
      slot_d  = '0;
      chan_d  = cmd_chan;
      rs_d    = cmd_resamp;
      burst_d = cmd_burst;
    end else if (seq_stop) begin
      st_d   = ST_IDLE;
      slot_d = '0;
    end else if (slot_next) begin
      case (st_q)
        ST_STREAM: begin
          if (map_last) begin
            slot_d = '0;
            adv    = 1'b1;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
        ST_SINGLE: if (!burst_q) st_d = ST_CRC;
        default: ;
      endcase
    end
  end

  assign ctl_en = cmd_load | seq_stop | slot_next;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      slot_q  <= '0;
      chan_q  <= '0;
      rs_q    <= 1'b0;
      burst_q <= 1'b0;
    end else if (ctl_en) begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      chan_q  <= chan_d;
      rs_q    <= rs_d;
      burst_q <= burst_d;
    end
  end

  // Outputs
  always_comb begin
    rd_addr = base;
    rd_sel  = SEL_FULL;
    case (st_q)
      ST_STREAM: begin
        rd_addr = base + ADDR_W'(map_off);
        rd_sel  = map_sel;
      end
      ST_CRC:  rd_sel = SEL_CRC;
      default: ;
    endcase
  end

  assign seq_active = (st_q != ST_IDLE);

  // R3 R4: slot counter never passes the largest slot of any pattern
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STREAM) |-> (slot_q <= SLOT_W'(SLOT_MAX)));

  // R7: once the CRC slot is reached it persists until a new command or stop
  a_r7_crc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_CRC && !cmd_load && !seq_stop) |=> (rd_sel == SEL_CRC));

  // R8: burst single-address slots repeat the same word
  a_r8_burst_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SINGLE && burst_q && slot_next && !cmd_load && !seq_stop)
      |=> ($stable(rd_addr) && rd_sel == SEL_FULL));

  // R10: stop leads to idle; idle ignores the slot strobe
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_stop && !cmd_load) |=> !seq_active);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_active && !cmd_load) |=> ($stable(rd_addr) && !seq_active));

endmodule

// File: tb/wfb_burst_seq_tb.sv
module wfb_burst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_load, cmd_resamp, cmd_burst, slot_next, seq_stop;
  logic [ADDR_W-1:0] cmd_addr;
  logic [3:0]        cmd_chan;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]        rd_sel;
  logic              seq_active;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfb_burst_seq #(.ADDR_W(ADDR_W), .FIX_LG(3), .RES_LG(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .cmd_chan(cmd_chan), .cmd_resamp(cmd_resamp), .cmd_burst(cmd_burst),
    .slot_next(slot_next), .seq_stop(seq_stop), .rd_addr(rd_addr),
    .rd_sel(rd_sel), .seq_active(seq_active)
  );

  task automatic chk(input string req, input int ea, input int es, input bit eact);
    n_chk++;
    if (int'(rd_addr) != ea || int'(rd_sel) != es || seq_active != eact) begin
      n_fail++;
      $display("FAIL %s: addr=%0h sel=%0d act=%0b expected addr=%0h sel=%0d act=%0b",
               req, rd_addr, rd_sel, seq_active, ea, es, eact);
    end
  endtask

  task automatic load(input int a, input int c, input bit r, input bit b);
    cmd_addr = ADDR_W'(a); cmd_chan = 4'(c); cmd_resamp = r; cmd_burst = b;
    cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic step();
    slot_next = 1'b1;
    @(negedge clk);
    slot_next = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 0, 0, 1'b0);
  endtask

  task automatic t_fixed_all();
    load(1, 0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) begin chk("R2 R3 fixed all", i, 0, 1'b1); step(); end
    chk("R4 fixed stride", 8, 0, 1'b1); step();
    chk("R4 fixed stride", 9, 0, 1'b1);
    load(20, 7, 1'b0, 1'b0);   // unused code behaves as all channels
    chk("R4 unused code", 16, 0, 1'b1); step();
    chk("R4 unused code", 17, 0, 1'b1);
  endtask

  task automatic t_fixed_phase();
    load(3, 1, 1'b0, 1'b0);
    chk("R4 phase A", 0, 0, 1'b1); step();
    chk("R4 phase A", 1, 0, 1'b1); step();
    chk("R4 phase A", 8, 0, 1'b1); step();
    chk("R4 phase A", 9, 0, 1'b1);
    load(17, 2, 1'b0, 1'b0);
    chk("R4 phase B", 18, 0, 1'b1); step();
    chk("R4 phase B", 19, 0, 1'b1); step();
    chk("R4 phase B", 26, 0, 1'b1);
    load(9, 4, 1'b0, 1'b0);
    chk("R4 neutral", 14, 0, 1'b1); step();
    chk("R4 neutral", 22, 0, 1'b1);
  endtask

  task automatic t_resamp();
    load(1, 3, 1'b1, 1'b0);
    for (int s = 0; s < 3; s++) begin
      chk("R5 R6 res phase C hi", 2 + 4*s, 1, 1'b1); step();
      chk("R5 R6 res phase C lo", 2 + 4*s, 2, 1'b1); step();
    end
    load(5, 0, 1'b1, 1'b0);
    for (int o = 0; o < 3; o++) begin
      chk("R5 res all hi", 4 + o, 1, 1'b1); step();
      chk("R5 res all lo", 4 + o, 2, 1'b1); step();
    end
    chk("R6 res all next set", 8, 1, 1'b1);
    load(6, 4, 1'b1, 1'b0);
    chk("R6 res neutral", 7, 0, 1'b1); step();
    chk("R6 res neutral", 11, 0, 1'b1);
  endtask

  task automatic t_single();
    load(13, 15, 1'b0, 1'b0);
    chk("R7 single word", 13, 0, 1'b1); step();
    chk("R7 crc slot", 13, 3, 1'b1); step();
    chk("R7 crc stays", 13, 3, 1'b1);
    load(13, 15, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin chk("R8 burst repeat", 13, 0, 1'b1); step(); end
  endtask

  task automatic t_wrap();
    load(12'h7F9, 0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) begin chk("R9 fixed near top", 12'h7F8 + i, 0, 1'b1); step(); end
    chk("R9 fixed wrap", 0, 0, 1'b1);
    load(12'h7FE, 3, 1'b1, 1'b0);
    chk("R9 res near top", 12'h7FE, 1, 1'b1); step();
    chk("R9 res near top", 12'h7FE, 2, 1'b1); step();
    chk("R9 res wrap", 2, 1, 1'b1);
  endtask

  task automatic t_stop();
    load(1, 0, 1'b0, 1'b0);
    step(); step();
    chk("R10 before stop", 2, 0, 1'b1);
    seq_stop = 1'b1;
    @(negedge clk);
    seq_stop = 1'b0;
    chk("R10 stopped", 0, 0, 1'b0);
    step(); step();
    chk("R10 strobe ignored idle", 0, 0, 1'b0);
  endtask

  task automatic t_precedence();
    load(1, 0, 1'b0, 1'b0);
    step();
    chk("R11 setup", 1, 0, 1'b1);
    slot_next = 1'b1;
    load(17, 0, 1'b0, 1'b0);
    slot_next = 1'b0;
    chk("R11 load wins", 16, 0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_load = 1'b0; cmd_addr = '0; cmd_chan = '0;
    cmd_resamp = 1'b0; cmd_burst = 1'b0; slot_next = 1'b0; seq_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed_all();
    t_fixed_phase();
    t_resamp();
    t_single();
    t_wrap();
    t_stop();
    t_precedence();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule